// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Sender

This block is the sending half of an inter-processor interrupt unit. Software programs a two-word command: a high word that names the target processor, and a low word that holds the vector, delivery mode, level flag, trigger mode and destination shorthand. A write to the low word launches the message. The block then takes a snapshot of both words and offers it on a valid/ready message interface toward the system interrupt bus.

While a message waits for the bus, a delivery-status bit reads as set in the low word, so software can poll it. A low-word write made while a message is still pending is dropped and sets a sticky send-error bit. The high word can be rewritten at any time. It never starts a message on its own, and it never changes a message that is already on the interface.

Supported uses are fixed vectored interrupts, INIT assert and deassert pairs, and start-up messages whose vector is the 4 KiB page number of the start address. The block has no special handling for these. It passes every field through to the message unchanged.

Top module: `ipi_cmd_sender`

## Requirements
- R1: After reset, msg_valid is 0 and both command words read as 0.
- R2: A write to offset 0x310 stores bits 31:24 as the destination ID, which reads back in bits 31:24 of 0x310 (other bits read 0). Such a write never raises msg_valid.
- R3: An accepted write to offset 0x300 raises msg_valid in the following cycle. The message then carries vector = bits 7:0, mode = bits 10:8, level = bit 14, trigger = bit 15, shorthand = bits 19:18, and destination = the stored high-word ID.
- R4: Bit 12 of the 0x300 read value (delivery status) is 1 from the cycle after a launch until the cycle after the edge where msg_valid and msg_ready are both 1. msg_valid then falls at the same time.
- R5: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and every message field holds its value.
- R6: A write to 0x300 while delivery status is 1 changes no stored field and no message field. It sets bit 13 (send error) of the 0x300 read value.
- R7: The send-error bit stays set until the next accepted write to 0x300, which clears it.
- R8: A write to 0x310 while a message is pending does not change that message's destination. It does apply to the next launch.
- R9: All four shorthand codes (0 destination field, 1 self, 2 all including self, 3 all excluding self) and the modes fixed (0), INIT (5) and start-up (6) pass unchanged. For start-up, the vector equals the start address divided by 4096.
- R10: An INIT sent with bit 14 set, and then resent with bit 14 clear, appears on the interface as level 1 and then level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| msg_valid | output | 1 | Message pending toward the bus |
| msg_ready | input | 1 | Bus accepts the message |
| msg_dest | output | 8 | Destination ID |
| msg_shorthand | output | 2 | Destination shorthand code |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level assert flag |
| msg_trigger | output | 1 | Trigger mode (1 level, 0 edge) |
| msg_vector | output | 8 | Vector or start-up page number |

## Verification
A stuck or lost busy state shows up within one cycle of a handshake. Either msg_valid stays up after acceptance, or the status bit fails to follow it. A snapshot that tracks the live registers instead of the launch values shows up as soon as a write lands during a pending message, when the destination or vector on the interface changes. The bench covers every combination of shorthand, mode, level and trigger. Around each one it checks the field mapping, the status and error bits, and the stability of the held message.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W = 32;
  localparam int DEST_W = 8;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;
  localparam int SH_W   = 2;

  // bit positions in the low command word
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int STAT_BIT  = 12;
  localparam int ERR_BIT   = 13;
  localparam int LVL_BIT   = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [SH_W-1:0]   shorthand;
    logic              trig;
    logic              level;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } ipi_msg_t;

  function automatic logic [DATA_W-1:0] low_word(ipi_msg_t m, logic busy, logic err);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VEC_LSB +: VEC_W]   = m.vector;
    w[MODE_LSB +: MODE_W] = m.mode;
    w[STAT_BIT]           = busy;
    w[ERR_BIT]            = err;
    w[LVL_BIT]            = m.level;
    w[TRIG_BIT]           = m.trig;
    w[SH_LSB +: SH_W]     = m.shorthand;
    return w;
  endfunction
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h300,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              launch,
  output logic              reject,
  output ipi_msg_t          cmd_next
);
  ipi_msg_t cmd_q, cmd_d;
  logic     lo_hit, hi_hit;
  logic     unused_wbits;

  assign lo_hit = wr_en && (addr == LO_OFS);
  assign hi_hit = wr_en && (addr == HI_OFS);
  assign launch = lo_hit && !busy;
  assign reject = lo_hit && busy;
  assign unused_wbits = ^{wdata[23:20], wdata[17:16], wdata[13:11]};

  always_comb begin
    cmd_d = cmd_q;
    if (hi_hit) cmd_d.dest = wdata[DEST_LSB +: DEST_W];
    if (launch) begin
      cmd_d.vector    = wdata[VEC_LSB +: VEC_W];
      cmd_d.mode      = wdata[MODE_LSB +: MODE_W];
      cmd_d.level     = wdata[LVL_BIT];
      cmd_d.trig      = wdata[TRIG_BIT];
      cmd_d.shorthand = wdata[SH_LSB +: SH_W];
    end
  end

  assign cmd_next = cmd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (hi_hit || launch) cmd_q <= cmd_d;
  end

  always_comb begin
    rdata = '0;
    if (addr == LO_OFS)      rdata = low_word(cmd_q, busy, err);
    else if (addr == HI_OFS) rdata[DEST_LSB +: DEST_W] = cmd_q.dest;
  end

  // R6: a rejected low write leaves stored low fields untouched
  p_reject_keeps_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !hi_hit) |=> $stable(cmd_q));
endmodule

// File: rtl/ipi_launch_ctrl.sv
module ipi_launch_ctrl
  import ipi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  logic     reject,
  input  ipi_msg_t cmd_next,
  input  logic     msg_ready,
  output logic     busy,
  output logic     err,
  output ipi_msg_t msg
);
  logic     busy_q, busy_d;
  logic     err_q, err_d;
  ipi_msg_t msg_q;
  logic     accept;

  assign accept = busy_q && msg_ready;

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    if (accept) busy_d = 1'b0;
    if (launch) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
    end
    if (reject) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msg_q <= '0;
    else if (launch) msg_q <= cmd_next;
  end

  assign busy = busy_q;
  assign err  = err_q;
  assign msg  = msg_q;

  // R5: pending message held until taken
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !msg_ready) |=> (busy_q && $stable(msg_q)));
  // R4: handshake retires the message
  p_accept_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !launch) |=> !busy_q);
  // R2: nothing but a low write starts a message
  p_no_spurious_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !launch) |=> !busy_q);
  // R6: a write during a pending message flags an error
  p_reject_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err_q);
endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h300,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic [1:0]        msg_shorthand,
  output logic [2:0]        msg_mode,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [7:0]        msg_vector
);
  logic     busy, err, launch, reject;
  ipi_msg_t cmd_next, msg;

  ipi_cmd_regs #(.ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .err(err), .rdata(reg_rdata),
    .launch(launch), .reject(reject), .cmd_next(cmd_next)
  );

  ipi_launch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch(launch), .reject(reject),
    .cmd_next(cmd_next), .msg_ready(msg_ready), .busy(busy), .err(err),
    .msg(msg)
  );

  assign msg_valid     = busy;
  assign msg_dest      = msg.dest;
  assign msg_shorthand = msg.shorthand;
  assign msg_mode      = msg.mode;
  assign msg_level     = msg.level;
  assign msg_trigger   = msg.trig;
  assign msg_vector    = msg.vector;

  // R3: a launch raises valid next cycle
  p_launch_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> msg_valid);
endmodule

// File: tb/ipi_cmd_sender_tb.sv
module ipi_cmd_sender_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;

  logic clk = 0, rst_n = 0, reg_wr = 0, msg_ready = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msg_valid, msg_level, msg_trigger;
  logic [7:0] msg_dest, msg_vector;
  logic [1:0] msg_shorthand;
  logic [2:0] msg_mode;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cmd_sender u_dut (.*);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic take();
    msg_ready = 1; @(posedge clk); @(negedge clk); msg_ready = 0;
  endtask

  function automatic logic [31:0] lo_word(int sh, int md, int lv, int tg, int vc);
    return (32'(sh) << 18) | (32'(tg) << 15) | (32'(lv) << 14) | (32'(md) << 8) | 32'(vc & 255);
  endfunction

  function automatic logic [63:0] fields(int d, int sh, int md, int lv, int tg, int vc);
    return {39'd0, 1'b1, 8'(d), 2'(sh), 3'(md), 1'(lv), 1'(tg), 8'(vc)};
  endfunction

  logic [63:0] cur;
  always_comb cur = {39'd0, msg_valid, msg_dest, msg_shorthand, msg_mode,
                     msg_level, msg_trigger, msg_vector};

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    chk("R1 valid", 64'(msg_valid), 0);
    rd(LO, v); chk("R1 low", 64'(v), 0);
    rd(HI, v); chk("R1 high", 64'(v), 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3/R4/R5/R9 sweep over shorthand, mode, level, trigger
    for (int i = 0; i < 48; i++) begin
      int sh, md, lv, tg, d, vc;
      sh = i % 4;
      md = ((i / 4) % 3 == 0) ? 0 : (((i / 4) % 3 == 1) ? 5 : 6);
      lv = (i / 12) % 2;
      tg = (i / 24) % 2;
      d  = (i * 37 + 5) % 256;
      if (md == 6) begin
        int page, pa;
        page = (i * 3 + 1) % 256;
        pa = page * 4096;
        vc = pa / 4096;
      end else vc = (i * 11 + 32) % 256;
      wr(HI, 32'(d) << 24);
      chk("R2 high no launch", 64'(msg_valid), 0);
      rd(HI, v); chk("R2 high readback", 64'(v), 64'(32'(d) << 24));
      wr(LO, lo_word(sh, md, lv, tg, vc));
      chk("R3 R9 fields", cur, fields(d, sh, md, lv, tg, vc));
      rd(LO, v); chk("R4 status set", 64'(v), 64'(lo_word(sh, md, lv, tg, vc) | 32'h1000));
      repeat (2) @(negedge clk);
      chk("R5 held", cur, fields(d, sh, md, lv, tg, vc));
      take();
      chk("R4 valid drop", 64'(msg_valid), 0);
      rd(LO, v); chk("R4 status clear", 64'(v[12]), 0);
    end

    // R6/R7/R8: writes while pending
    wr(HI, 32'h11 << 24);
    wr(LO, lo_word(1, 0, 1, 0, 8'h40));
    wr(LO, lo_word(3, 6, 0, 1, 8'h99));
    chk("R6 msg unchanged", cur, fields(8'h11, 1, 0, 1, 0, 8'h40));
    rd(LO, v); chk("R6 stored+err", 64'(v), 64'(lo_word(1, 0, 1, 0, 8'h40) | 32'h3000));
    wr(HI, 32'h22 << 24);
    chk("R8 dest held", 64'(msg_dest), 64'h11);
    rd(HI, v); chk("R8 high updated", 64'(v), 64'(32'h22 << 24));
    take();
    rd(LO, v); chk("R7 err sticky", 64'(v[13]), 1);
    wr(LO, lo_word(2, 0, 0, 0, 8'h41));
    chk("R8 new dest", 64'(msg_dest), 64'h22);
    rd(LO, v); chk("R7 err cleared", 64'(v[13]), 0);
    take();

    // R10: INIT assert then deassert
    wr(LO, lo_word(0, 5, 1, 1, 0));
    chk("R10 assert", 64'({msg_mode, msg_level}), 64'({3'd5, 1'b1}));
    take();
    wr(LO, lo_word(0, 5, 0, 1, 0));
    chk("R10 deassert", 64'({msg_mode, msg_level}), 64'({3'd5, 1'b0}));
    take();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule